// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is one GPIO port with up to eight pins behind a small synchronous register bus. Each pin owns a 32-byte register window. Through it software sets the pin's enable and direction, floats or drives its pad, sets the driven level, reads back the filtered input level and clears the pin's pending interrupt. Every pad input passes through a two-flop synchroniser and then an optional debounce filter. The filter counts a stable level in ticks of a millisecond prescaler before it accepts a change.

The filtered level feeds a trigger detector. The detector takes a two-bit type (none, level, single edge, double edge) and a polarity bit. When an enabled pin meets its trigger condition, the detector latches a pending flag. A status word shows all pending flags as a bitmap. A single interrupt output goes high when any pending flag has its per-pin interrupt enable set. Clearing that enable masks the pin and leaves its trigger setup and its pending flag as they are.

Top module: `gpio_port`

## Requirements
- R1: After reset, every configuration, threshold and output-value field is 0 and every output-control float bit is 1. The status bitmap reads 0, `irq_o` is low and every `pad_oe_o` bit is low.
- R2: Pin n owns the bus byte addresses n*0x20 to n*0x20+0x1F. Offset 0x00 is the 7-bit config. Offset 0x04 is the debounce threshold, of which only bits 7:0 are kept. Offset 0x08 is the input (bit 0). Offset 0x0C is the float bit (bit 0). Offset 0x10 is the output value (bit 0). Offset 0x14 is the clear. Reads return the stored value one cycle after `rd_en_i`.
- R3: Config bit 0 enables the pin and bit 1 selects output. `pad_oe_o[n]` is high only when both bits are set and the float bit is 0. `pad_o[n]` follows the output-value bit.
- R4: Input bit 0 shows the filtered pad level. With filtering off, it follows the pad through a two-flop synchroniser.
- R5: Config bit 5 enables debounce. When the bit is set and the threshold is nonzero, the filtered level changes only after the synchronised pad has differed from it for the threshold number of consecutive ticks. A tick comes every TICK_CYCLES clocks. A shorter pulse is discarded. A threshold of 0 passes the level straight through.
- R6: Trigger type 2 (config bits 3:2) is single edge. Polarity 1 (bit 4) latches pending on a rising edge and ignores falling edges. Polarity 0 does the reverse.
- R7: Trigger type 3 latches pending on both rising and falling edges, whatever the polarity.
- R8: Trigger type 1 is level. Pending latches while the filtered level equals the polarity. It is set again on the next cycle after a clear if the level still holds.
- R9: Type 0, or config bit 0 being clear, never sets pending.
- R10: Any write to offset 0x14 of a pin clears that pin's pending flag.
- R11: Address 0x104 reads a bitmap with bit n set when pin n is pending. Writes to 0x104 have no effect.
- R12: `irq_o` is high when some pin is pending and has config bit 6 set. Clearing bit 6 drops that pin's share of `irq_o` and leaves its pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 9 | Bus byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| pad_i | input | N_PINS | Raw pad levels |
| pad_o | output | N_PINS | Driven pad levels |
| pad_oe_o | output | N_PINS | Pad driver enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong detector or pending state shows up in the status bitmap and on `irq_o` on the clock after the filtered level moves. The filtered level itself trails the pad by two synchroniser clocks, plus the debounce window when filtering is on. A stuck debounce counter shows up as an input bit that never changes, or that changes after too few ticks. The input register reveals it at the next read. A broken float or direction bit shows on `pad_oe_o` one clock after the write. The checks therefore sample status, input and pad outputs a few cycles after each stimulus, at the points where the timing leaves no doubt about the expected value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef struct packed {
        logic       irq_en;
        logic       deb_en;
        logic       pol;
        logic [1:0] trig;
        logic       dir_out;
        logic       en;
    } pin_cfg_t;

    localparam logic [1:0] TRIG_NONE   = 2'd0;
    localparam logic [1:0] TRIG_LEVEL  = 2'd1;
    localparam logic [1:0] TRIG_SINGLE = 2'd2;
    localparam logic [1:0] TRIG_DOUBLE = 2'd3;

    localparam logic [2:0] OFF_CFG  = 3'd0;
    localparam logic [2:0] OFF_DEB  = 3'd1;
    localparam logic [2:0] OFF_IN   = 3'd2;
    localparam logic [2:0] OFF_OCTL = 3'd3;
    localparam logic [2:0] OFF_OVAL = 3'd4;
    localparam logic [2:0] OFF_CLR  = 3'd5;

    localparam int          ADDR_W      = 9;
    localparam logic [8:0]  STATUS_ADDR = 9'h104;

endpackage

// File: rtl/gpio_tick.sv
module gpio_tick #(
    parameter int TICK_CYCLES = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CNT_W = $clog2(TICK_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == CNT_W'(TICK_CYCLES - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_port_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        tick_i,
    input  logic        pad_i,
    input  logic        wr_i,
    input  logic [2:0]  off_i,
    input  logic [31:0] wdata_i,
    output pin_cfg_t    cfg_o,
    output logic [7:0]  thr_o,
    output logic        level_o,
    output logic        float_o,
    output logic        oval_o,
    output logic        pend_o,
    output logic        pad_o,
    output logic        pad_oe_o
);
    typedef struct packed {
        pin_cfg_t   cfg;
        logic [7:0] thr;
        logic       flt;
        logic       oval;
        logic [1:0] sync;
        logic       level;
        logic [7:0] cnt;
        logic       pend;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    raw, filter_on, rise, fall, hit, clr;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pad_i};
        raw       = st_q.sync[1];
        filter_on = st_q.cfg.deb_en && (st_q.thr != 8'd0);

        // debounce: accept a change after thr stable ticks
        if (!filter_on || raw == st_q.level) begin
            st_d.cnt = '0;
            if (!filter_on) st_d.level = raw;
        end else if (tick_i) begin
            if ({1'b0, st_q.cnt} + 9'd1 >= {1'b0, st_q.thr}) begin
                st_d.level = raw;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 8'd1;
            end
        end

        rise = !st_q.level && st_d.level;
        fall = st_q.level && !st_d.level;
        unique case (st_q.cfg.trig)
            TRIG_LEVEL:  hit = (st_q.level == st_q.cfg.pol);
            TRIG_SINGLE: hit = st_q.cfg.pol ? rise : fall;
            TRIG_DOUBLE: hit = rise || fall;
            default:     hit = 1'b0;
        endcase
        hit = hit && st_q.cfg.en;

        clr       = wr_i && (off_i == OFF_CLR);
        st_d.pend = (st_q.pend && !clr) || hit;

        if (wr_i) begin
            case (off_i)
                OFF_CFG:  st_d.cfg  = pin_cfg_t'(wdata_i[6:0]);
                OFF_DEB:  st_d.thr  = wdata_i[7:0];
                OFF_OCTL: st_d.flt  = wdata_i[0];
                OFF_OVAL: st_d.oval = wdata_i[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.flt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o    = st_q.cfg;
    assign thr_o    = st_q.thr;
    assign level_o  = st_q.level;
    assign float_o  = st_q.flt;
    assign oval_o   = st_q.oval;
    assign pend_o   = st_q.pend;
    assign pad_o    = st_q.oval;
    assign pad_oe_o = st_q.cfg.en && st_q.cfg.dir_out && !st_q.flt;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int TICK_CYCLES = 200000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [8:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [N_PINS-1:0] pad_i,
    output logic [N_PINS-1:0] pad_o,
    output logic [N_PINS-1:0] pad_oe_o,
    output logic              irq_o
);
    localparam int IDX_W = 3;

    typedef struct packed {
        logic [31:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;

    logic                  tick;
    logic                  in_win;
    logic [IDX_W-1:0]      pin_idx;
    logic [2:0]            off;
    logic [N_PINS-1:0][6:0] cfg_vec;
    logic [N_PINS-1:0][7:0] thr_vec;
    logic [N_PINS-1:0]     level_vec, float_vec, oval_vec, pend_vec, ien_vec;

    assign in_win  = !addr_i[8];
    assign pin_idx = addr_i[7:5];
    assign off     = addr_i[4:2];

    gpio_tick #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        pin_cfg_t cfg_w;
        logic     sel;
        assign sel = wr_en_i && in_win && (pin_idx == IDX_W'(g));

        gpio_pin pin_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (tick),
            .pad_i   (pad_i[g]),
            .wr_i    (sel),
            .off_i   (off),
            .wdata_i (wdata_i),
            .cfg_o   (cfg_w),
            .thr_o   (thr_vec[g]),
            .level_o (level_vec[g]),
            .float_o (float_vec[g]),
            .oval_o  (oval_vec[g]),
            .pend_o  (pend_vec[g]),
            .pad_o   (pad_o[g]),
            .pad_oe_o(pad_oe_o[g])
        );
        assign cfg_vec[g] = cfg_w;
        assign ien_vec[g] = cfg_w.irq_en;
    end

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.rdata = '0;
            if (addr_i == STATUS_ADDR) begin
                st_d.rdata = 32'(pend_vec);
            end else if (in_win) begin
                for (int i = 0; i < N_PINS; i++) begin
                    if (pin_idx == IDX_W'(i)) begin
                        case (off)
                            OFF_CFG:  st_d.rdata = 32'(cfg_vec[i]);
                            OFF_DEB:  st_d.rdata = 32'(thr_vec[i]);
                            OFF_IN:   st_d.rdata = 32'(level_vec[i]);
                            OFF_OCTL: st_d.rdata = 32'(float_vec[i]);
                            OFF_OVAL: st_d.rdata = 32'(oval_vec[i]);
                            default:  st_d.rdata = '0;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = |(pend_vec & ien_vec);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int N_PINS = 8
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   wr_en_i,
    input logic [8:0]             addr_i,
    input logic                   irq_o,
    input logic [N_PINS-1:0]      pad_oe_o,
    input logic [N_PINS-1:0]      pend_vec,
    input logic [N_PINS-1:0][6:0] cfg_vec,
    input logic [N_PINS-1:0]      level_vec
);
    // R1: leaving reset, nothing is pending or driven
    a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (pend_vec == '0) && (pad_oe_o == '0));

    // R12: the interrupt needs a pending source
    a_r12_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (pend_vec != '0));

    for (genvar g = 0; g < N_PINS; g++) begin : g_chk
        logic clr_wr;
        assign clr_wr = wr_en_i && !addr_i[8] && (addr_i[7:5] == 3'(g))
                        && (addr_i[4:2] == 3'd5);

        // R9: pending only rises on an enabled pin with a trigger type
        a_r9_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pend_vec[g]) |-> $past(cfg_vec[g][0] && (cfg_vec[g][3:2] != 2'd0)));

        // R10: a clear on a pin with no trigger leaves it idle
        a_r10_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_wr && cfg_vec[g][3:2] == 2'd0) |=> !pend_vec[g]);

        // R8: a held level keeps pending set
        a_r8_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_vec[g][0] && cfg_vec[g][3:2] == 2'd1 && level_vec[g] == cfg_vec[g][4])
            |=> pend_vec[g]);
    end
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .irq_o    (irq_o),
    .pad_oe_o (pad_oe_o),
    .pend_vec (pend_vec),
    .cfg_vec  (cfg_vec),
    .level_vec(level_vec)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [N-1:0] pad = '0, pad_out, pad_oe;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    gpio_port #(.N_PINS(N), .TICK_CYCLES(4)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .pad_i(pad), .pad_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
    );

    // {cfg[6:0], level before, level after, expected pending}
    localparam logic [9:0] VEC [12] = '{
        {7'h41, 1'b0, 1'b1, 1'b0},   // R9 none
        {7'h59, 1'b0, 1'b1, 1'b1},   // R6 rising
        {7'h59, 1'b1, 1'b0, 1'b0},   // R6 rising ignores fall
        {7'h49, 1'b1, 1'b0, 1'b1},   // R6 falling
        {7'h49, 1'b0, 1'b1, 1'b0},   // R6 falling ignores rise
        {7'h4D, 1'b0, 1'b1, 1'b1},   // R7 both, pol 0
        {7'h5D, 1'b1, 1'b0, 1'b1},   // R7 both, pol 1
        {7'h55, 1'b0, 1'b1, 1'b1},   // R8 level high
        {7'h55, 1'b0, 1'b0, 1'b0},   // R8 level high, stays low
        {7'h45, 1'b1, 1'b0, 1'b1},   // R8 level low
        {7'h45, 1'b1, 1'b1, 1'b0},   // R8 level low, stays high
        {7'h58, 1'b0, 1'b1, 1'b0}    // R9 pin disabled
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        bus_rd(9'h104, rv); check("R1 status", rv, 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 pad_oe", 32'(pad_oe), 0);
        bus_rd(9'h00C, rv); check("R1 float", rv, 1);

        // trigger table on pin 0
        for (int k = 0; k < 12; k++) begin
            bus_wr(9'h000, 32'h41);
            pad[0] = VEC[k][2];
            wait_cyc(8);
            bus_wr(9'h000, 32'(VEC[k][9:3]));
            wait_cyc(2);
            bus_wr(9'h014, 0);
            wait_cyc(2);
            pad[0] = VEC[k][1];
            wait_cyc(8);
            bus_rd(9'h104, rv);
            check($sformatf("R6/R7/R8/R9 vec%0d status", k), 32'(rv[0]), 32'(VEC[k][0]));
            check($sformatf("R12 vec%0d irq", k), 32'(irq), 32'(VEC[k][0]));
        end

        // R11 bitmap, R10 clear, R12 mask
        pad = '0;
        bus_wr(9'h000, 32'h59);
        bus_wr(9'h060, 32'h59);
        wait_cyc(6);
        bus_wr(9'h014, 0);
        bus_wr(9'h074, 0);
        pad[0] = 1'b1; pad[3] = 1'b1;
        wait_cyc(8);
        bus_rd(9'h104, rv); check("R11 bitmap", rv, 32'h09);
        bus_wr(9'h104, 0);
        bus_rd(9'h104, rv); check("R11 write ignored", rv, 32'h09);
        bus_wr(9'h014, 0);
        bus_rd(9'h104, rv); check("R10 clear", rv, 32'h08);
        bus_wr(9'h060, 32'h19);
        wait_cyc(1);
        check("R12 masked irq", 32'(irq), 0);
        bus_rd(9'h104, rv); check("R12 pending kept", rv, 32'h08);
        bus_wr(9'h060, 32'h59);
        wait_cyc(1);
        check("R12 unmasked irq", 32'(irq), 1);

        // R8 level re-asserts after clear
        pad[4] = 1'b1;
        bus_wr(9'h080, 32'h55);
        wait_cyc(6);
        bus_wr(9'h094, 0);
        wait_cyc(3);
        bus_rd(9'h104, rv); check("R8 reassert", 32'(rv[4]), 1);

        // R3 pad drive on pin 1, R2 readback
        bus_wr(9'h030, 1);
        bus_wr(9'h02C, 0);
        bus_wr(9'h020, 32'h03);
        wait_cyc(1);
        check("R3 oe on", 32'(pad_oe[1]), 1);
        check("R3 level", 32'(pad_out[1]), 1);
        bus_wr(9'h02C, 1);
        wait_cyc(1);
        check("R3 float", 32'(pad_oe[1]), 0);
        bus_rd(9'h030, rv); check("R2 oval readback", rv, 1);
        bus_rd(9'h020, rv); check("R2 cfg readback", rv, 32'h03);

        // R5 debounce on pin 2
        bus_wr(9'h044, 32'h1FF);
        bus_rd(9'h044, rv); check("R2 thr width", rv, 32'hFF);
        bus_wr(9'h044, 3);
        bus_wr(9'h040, 32'h21);
        pad[2] = 1'b1;
        wait_cyc(3);
        bus_rd(9'h048, rv); check("R5 held early", rv, 0);
        wait_cyc(30);
        bus_rd(9'h048, rv); check("R5 accepted", rv, 1);
        pad[2] = 1'b0;
        wait_cyc(4);
        pad[2] = 1'b1;
        wait_cyc(30);
        bus_rd(9'h048, rv); check("R5 glitch dropped", rv, 1);
        bus_wr(9'h040, 32'h01);
        pad[2] = 1'b0;
        wait_cyc(4);
        bus_rd(9'h048, rv); check("R4 direct", rv, 0);
        bus_wr(9'h044, 0);
        bus_wr(9'h040, 32'h21);
        pad[2] = 1'b1;
        wait_cyc(4);
        bus_rd(9'h048, rv); check("R5 zero threshold", rv, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule